// File: doc/BRIEF.md
# Power-Down Entry and Wake Sequencer

This block sequences a processor into and out of a dormant low-power state. A request arrives either as an assertion of an active-low power-down pin or as a one-cycle software force strobe. The block answers with a nonmaskable, edge-triggered interrupt pulse and keeps every clock running. Software may then run any amount of cleanup code. When it issues an enter strobe, the block gates the core clock and the clock output pin. It can also stop the oscillator, if that was configured at entry.

While dormant, either a deassertion of the power-down pin or a rising edge on an external wake input starts recovery. The recovery counter runs on the free-running input clock. It counts a short delay if the oscillator kept running and a long one if it was stopped, and then re-enables the core clock from a register, so the enable cannot glitch. An exit mode captured at entry decides whether the core resumes from its saved context or is told, by a one-cycle pulse, to start from a cleared context. The pin and the wake input are asynchronous and pass through two synchronizer stages. The software strobes are synchronous to clk_i.

Top module: `pwrdn_seq`

## Requirements
- R1: After reset, core_clk_en_o, osc_en_o and clkout_en_o are 1, and pd_irq_o and ctx_clear_o are 0.
- R2: In the running state, a high-to-low change of pd_req_ni raises pd_irq_o for exactly one cycle, starting at the 3rd rising clk_i edge after the change. All clock enables stay 1.
- R3: In the running state, sw_force_i sampled high at an edge raises pd_irq_o for exactly one cycle, starting at that edge.
- R4: sw_enter_i has no effect unless a power-down interrupt is pending: in the running state core_clk_en_o stays 1.
- R5: sw_enter_i sampled high while pending drops core_clk_en_o and clkout_en_o at that edge. osc_en_o drops at the same edge exactly when osc_stop_i is 1 at that edge.
- R6: When the oscillator kept running, a low-to-high change of pd_req_ni while dormant brings core_clk_en_o back high at the (FAST_CYC+4)th rising edge after the change. osc_en_o stays 1 throughout.
- R7: When the oscillator was stopped, a wake event brings osc_en_o high at the 3rd rising edge and core_clk_en_o high at the (SLOW_CYC+4)th rising edge after the input change.
- R8: While dormant, a low-to-high change of wake_i is a wake event with the same timing as R6 and R7.
- R9: Changes of pd_req_ni during the recovery count neither restart nor shorten it, and raise no interrupt.
- R10: If ctx_clear_i is 1 at the enter edge, ctx_clear_o pulses for exactly one cycle, in the cycle in which core_clk_en_o rises. Otherwise ctx_clear_o stays 0.
- R11: clkout_off_i high drives clkout_en_o low from the next edge on. With clkout_off_i low, clkout_en_o follows core_clk_en_o.
- R12: Outside the running state, sw_force_i and pin assertions raise no pd_irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_req_ni | input | 1 | Power-down pin, active low, asynchronous |
| wake_i | input | 1 | External wake request, asynchronous, rising edge |
| sw_force_i | input | 1 | Software power-down force strobe |
| sw_enter_i | input | 1 | Software enter-dormant strobe |
| osc_stop_i | input | 1 | Stop oscillator while dormant, captured at entry |
| ctx_clear_i | input | 1 | Exit with cleared context, captured at entry |
| clkout_off_i | input | 1 | Disable clock output pin |
| pd_irq_o | output | 1 | Power-down interrupt pulse |
| core_clk_en_o | output | 1 | Core clock gate enable |
| osc_en_o | output | 1 | Oscillator enable |
| clkout_en_o | output | 1 | Clock output pin enable |
| ctx_clear_o | output | 1 | Start-from-cleared-context pulse on exit |

## Verification
A wrong state shows up first on the clock enables. A sequencer that leaves the pending state early drops core_clk_en_o without an enter strobe, and it does so at that same edge. A wrong count load or a restart moves the rise of core_clk_en_o away from the expected edge, by anything from a single cycle to thousands of cycles. That is why every rise and fall is checked against an exact edge number. A stale exit or oscillator mode appears as a ctx_clear_o pulse or an osc_en_o drop in the wrong wake cycle. A missed run-state check appears as an extra pd_irq_o pulse within three cycles of the stray stimulus.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_PEND = 3'd1,
    ST_DORM = 3'd2,
    ST_WAKE = 3'd3,
    ST_RES  = 3'd4
  } pd_state_e;
endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
  parameter int         W       = 2,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwrdn_edge.sv
module pwrdn_edge #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= lvl_i;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign rise_o[b] = lvl_i[b] & ~prev_q[b];
    assign fall_o[b] = ~lvl_i[b] & prev_q[b];
  end
endmodule

// File: rtl/pwrdn_wake_timer.sv
module pwrdn_wake_timer #(
  parameter int FAST_CYC = 200,
  parameter int SLOW_CYC = 4096,
  localparam int CNT_W   = $clog2(SLOW_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic slow_i,
  output logic zero_o
);
  localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(FAST_CYC);
  localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(SLOW_CYC);

  logic [CNT_W-1:0] cnt_q;

  // runs from the ungated input clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= slow_i ? SLOW_LD : FAST_LD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
  import pwrdn_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_rise_i,
  input  logic pd_fall_i,
  input  logic wake_rise_i,
  input  logic sw_force_i,
  input  logic sw_enter_i,
  input  logic osc_stop_i,
  input  logic ctx_clear_i,
  input  logic clkout_off_i,
  input  logic tmr_zero_i,
  output logic tmr_load_o,
  output logic tmr_slow_o,
  output logic pd_irq_o,
  output logic core_clk_en_o,
  output logic osc_en_o,
  output logic clkout_en_o,
  output logic ctx_clear_o
);
  pd_state_e state_q, state_d;
  logic osc_mode_q, ctx_mode_q;
  logic irq_q, clk_en_q, osc_en_q, clkout_q, ctx_q;
  logic req_evt, wake_evt, enter_evt, osc_stop_d, clk_en_d;

  assign req_evt   = pd_rise_i | sw_force_i;
  assign wake_evt  = pd_fall_i | wake_rise_i;
  assign enter_evt = (state_q == ST_PEND) & sw_enter_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (req_evt)    state_d = ST_PEND;
      ST_PEND: if (sw_enter_i) state_d = ST_DORM;
      ST_DORM: if (wake_evt)   state_d = ST_WAKE;
      ST_WAKE: if (tmr_zero_i) state_d = ST_RES;
      ST_RES:                  state_d = ST_RUN;
      default:                 state_d = ST_RUN;
    endcase
  end

  assign osc_stop_d = enter_evt ? osc_stop_i : osc_mode_q;
  assign clk_en_d   = !(state_d inside {ST_DORM, ST_WAKE});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      osc_mode_q <= 1'b0;
      ctx_mode_q <= 1'b0;
      irq_q      <= 1'b0;
      clk_en_q   <= 1'b1;
      osc_en_q   <= 1'b1;
      clkout_q   <= 1'b1;
      ctx_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (enter_evt) begin
        osc_mode_q <= osc_stop_i;
        ctx_mode_q <= ctx_clear_i;
      end
      irq_q    <= (state_q == ST_RUN) & req_evt;
      clk_en_q <= clk_en_d;
      osc_en_q <= !((state_d == ST_DORM) & osc_stop_d);
      clkout_q <= !clkout_off_i & clk_en_d;
      ctx_q    <= (state_d == ST_RES) & ctx_mode_q;
    end
  end

  assign tmr_load_o    = (state_q == ST_DORM) & wake_evt;
  assign tmr_slow_o    = osc_mode_q;
  assign pd_irq_o      = irq_q;
  assign core_clk_en_o = clk_en_q;
  assign osc_en_o      = osc_en_q;
  assign clkout_en_o   = clkout_q;
  assign ctx_clear_o   = ctx_q;
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
  parameter int FAST_CYC    = 200,
  parameter int SLOW_CYC    = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_req_ni,
  input  logic wake_i,
  input  logic sw_force_i,
  input  logic sw_enter_i,
  input  logic osc_stop_i,
  input  logic ctx_clear_i,
  input  logic clkout_off_i,
  output logic pd_irq_o,
  output logic core_clk_en_o,
  output logic osc_en_o,
  output logic clkout_en_o,
  output logic ctx_clear_o
);
  localparam int NIN = 2;  // bit 0: pin, bit 1: wake

  logic [NIN-1:0] raw_in, sync_q, act, rise, fall;
  logic tmr_load, tmr_slow, tmr_zero;

  assign raw_in = {wake_i, pd_req_ni};

  pwrdn_sync #(
    .W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)
  ) i_sync (
    .clk_i, .rst_ni, .d_i(raw_in), .q_o(sync_q)
  );

  // pin is active low; make both active high
  assign act = {sync_q[1], ~sync_q[0]};

  pwrdn_edge #(.W(NIN)) i_edge (
    .clk_i, .rst_ni, .lvl_i(act), .rise_o(rise), .fall_o(fall)
  );

  pwrdn_wake_timer #(
    .FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)
  ) i_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .slow_i(tmr_slow), .zero_o(tmr_zero)
  );

  pwrdn_fsm i_fsm (
    .clk_i, .rst_ni,
    .pd_rise_i(rise[0]), .pd_fall_i(fall[0]), .wake_rise_i(rise[1]),
    .sw_force_i, .sw_enter_i, .osc_stop_i, .ctx_clear_i, .clkout_off_i,
    .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_slow_o(tmr_slow),
    .pd_irq_o, .core_clk_en_o, .osc_en_o, .clkout_en_o, .ctx_clear_o
  );
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sw_enter_i,
  input logic pd_irq_o,
  input logic core_clk_en_o,
  input logic osc_en_o,
  input logic clkout_en_o,
  input logic ctx_clear_o
);
  // R2 / R3
  a_r2_irq_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_irq_o |=> !pd_irq_o);

  // R5
  a_r5_gate_needs_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_clk_en_o) |-> $past(sw_enter_i));

  // R7
  a_r7_osc_before_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_clk_en_o |-> osc_en_o);

  // R10
  a_r10_ctx_with_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_clear_o |-> $rose(core_clk_en_o));

  // R11
  a_r11_clkout_under_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clkout_en_o |-> core_clk_en_o);

  // R12
  a_r12_no_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_clk_en_o |-> !pd_irq_o);
endmodule

bind pwrdn_seq pwrdn_seq_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sw_enter_i(sw_enter_i),
  .pd_irq_o(pd_irq_o), .core_clk_en_o(core_clk_en_o), .osc_en_o(osc_en_o),
  .clkout_en_o(clkout_en_o), .ctx_clear_o(ctx_clear_o)
);

// File: tb/test_pwrdn_seq.sv
`timescale 1ns/1ps
module test_pwrdn_seq;
  localparam int FAST = 200;
  localparam int SLOW = 4096;
  localparam int K_IRQ = 0, K_CRISE = 1, K_CFALL = 2, K_ORISE = 3, K_OFALL = 4, K_CTX = 5;

  typedef struct { int kind; int cyc; string req; } exp_t;

  logic clk_i = 0, rst_ni = 0;
  logic pd_req_ni = 1, wake_i = 0, sw_force_i = 0, sw_enter_i = 0;
  logic osc_stop_i = 0, ctx_clear_i = 0, clkout_off_i = 0;
  logic pd_irq_o, core_clk_en_o, osc_en_o, clkout_en_o, ctx_clear_o;

  int cyc = 0, tests = 0, fails = 0;
  bit done = 0;
  exp_t expq[$];
  logic p_clk = 1, p_osc = 1;
  string kname [6] = '{"irq", "clk_rise", "clk_fall", "osc_rise", "osc_fall", "ctx_clear"};

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  pwrdn_seq #(.FAST_CYC(FAST), .SLOW_CYC(SLOW)) i_pwrdn_seq (
    .clk_i, .rst_ni, .pd_req_ni, .wake_i, .sw_force_i, .sw_enter_i,
    .osc_stop_i, .ctx_clear_i, .clkout_off_i,
    .pd_irq_o, .core_clk_en_o, .osc_en_o, .clkout_en_o, .ctx_clear_o
  );

  task automatic chk(string req, logic act, logic exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic push(int kind, int at, string req);
    exp_t e;
    e.kind = kind; e.cyc = at; e.req = req;
    expq.push_back(e);
  endtask

  // monitor: match each observed event against the scoreboard
  task automatic match(int kind);
    int idx = -1;
    for (int i = 0; i < expq.size(); i++)
      if (idx < 0 && expq[i].kind == kind) idx = i;
    tests++;
    if (idx < 0) begin
      fails++;
      $display("FAIL unexpected %s at cycle %0d: actual event expected none", kname[kind], cyc);
    end else begin
      if (expq[idx].cyc != cyc) begin
        fails++;
        $display("FAIL %s %s: actual cycle %0d expected %0d",
                 expq[idx].req, kname[kind], cyc, expq[idx].cyc);
      end
      expq.delete(idx);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (pd_irq_o) match(K_IRQ);
      if (core_clk_en_o && !p_clk) match(K_CRISE);
      if (!core_clk_en_o && p_clk) match(K_CFALL);
      if (osc_en_o && !p_osc) match(K_ORISE);
      if (!osc_en_o && p_osc) match(K_OFALL);
      if (ctx_clear_o) match(K_CTX);
      p_clk = core_clk_en_o;
      p_osc = osc_en_o;
    end
  end

  // drivers: all act at a negedge; edge m after drive is cycle cyc+m
  task automatic pin_assert(string req);
    @(negedge clk_i); pd_req_ni = 0;
    if (req != "") push(K_IRQ, cyc + 3, req);
  endtask

  task automatic force_pd(bit expect_irq, string req);
    @(negedge clk_i); sw_force_i = 1;
    if (expect_irq) push(K_IRQ, cyc + 1, req);
    @(negedge clk_i); sw_force_i = 0;
  endtask

  task automatic enter(bit stop_osc, bit clr_ctx, bit expect_gate);
    @(negedge clk_i);
    osc_stop_i = stop_osc; ctx_clear_i = clr_ctx; sw_enter_i = 1;
    if (expect_gate) begin
      push(K_CFALL, cyc + 1, "R5");
      if (stop_osc) push(K_OFALL, cyc + 1, "R5");
    end
    @(negedge clk_i); sw_enter_i = 0; osc_stop_i = 0; ctx_clear_i = 0;
  endtask

  task automatic expect_wake(bit stopped, bit clr, string req);
    int n = stopped ? SLOW : FAST;
    push(K_CRISE, cyc + n + 4, req);
    if (stopped) push(K_ORISE, cyc + 3, "R7");
    if (clr) push(K_CTX, cyc + n + 4, "R10");
  endtask

  task automatic drain();
    for (int i = 0; i < 6000 && expq.size() != 0; i++) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1", core_clk_en_o, 1'b1, "core_clk_en_o");
    chk("R1", osc_en_o, 1'b1, "osc_en_o");
    chk("R1", clkout_en_o, 1'b1, "clkout_en_o");
    chk("R1", pd_irq_o, 1'b0, "pd_irq_o");
    chk("R1", ctx_clear_o, 1'b0, "ctx_clear_o");

    // R4: enter strobe while running is ignored
    enter(1'b1, 1'b0, 1'b0);
    repeat (4) @(negedge clk_i);
    chk("R4", core_clk_en_o, 1'b1, "core_clk_en_o after stray enter");
    chk("R4", osc_en_o, 1'b1, "osc_en_o after stray enter");

    // R2 pin request, oscillator kept, wake by pin release (R6)
    pin_assert("R2");
    drain();
    chk("R2", core_clk_en_o, 1'b1, "clock still running while pending");
    force_pd(1'b0, "R12");  // pending: no new interrupt
    enter(1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk_i);
    chk("R5", clkout_en_o, 1'b0, "clkout_en_o dormant");
    chk("R5", osc_en_o, 1'b1, "osc_en_o kept running");
    force_pd(1'b0, "R12");  // dormant: no interrupt
    @(negedge clk_i); pd_req_ni = 1;
    expect_wake(1'b0, 1'b0, "R6");
    drain();
    chk("R6", clkout_en_o, 1'b1, "clkout_en_o after wake");

    // R3 software request, oscillator stopped, wake by wake_i (R8), exit clear
    force_pd(1'b1, "R3");
    drain();
    enter(1'b1, 1'b1, 1'b1);
    repeat (5) @(negedge clk_i);
    @(negedge clk_i); wake_i = 1;
    expect_wake(1'b1, 1'b1, "R8");
    // R9: pin activity during recovery is ignored
    repeat (50) @(negedge clk_i);
    pd_req_ni = 0;
    repeat (50) @(negedge clk_i);
    pd_req_ni = 1;
    drain();
    wake_i = 0;
    chk("R9", pd_irq_o, 1'b0, "no interrupt after recovery");

    // R7 via pin wake, oscillator stopped, keep context
    pin_assert("R2");
    drain();
    enter(1'b1, 1'b0, 1'b1);
    repeat (3) @(negedge clk_i);
    chk("R7", osc_en_o, 1'b0, "osc_en_o stopped while dormant");
    @(negedge clk_i); pd_req_ni = 1;
    expect_wake(1'b1, 1'b0, "R7");
    drain();

    // R11 clock output disable while running
    @(negedge clk_i); clkout_off_i = 1;
    @(negedge clk_i);
    chk("R11", clkout_en_o, 1'b0, "clkout_en_o with off");
    chk("R11", core_clk_en_o, 1'b1, "core clock unaffected");
    clkout_off_i = 0;
    @(negedge clk_i);
    chk("R11", clkout_en_o, 1'b1, "clkout_en_o released");

    done = 1;
    foreach (expq[i]) begin
      tests++; fails++;
      $display("FAIL %s %s: actual none expected cycle %0d", expq[i].req, kname[expq[i].kind], expq[i].cyc);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule